// File: doc/BRIEF.md
# Opcode-Triggered Write-Data Override Engine

This block sits behind a cartridge edge connector and serves ROM reads to a CPU whose only outputs to the cartridge are an address bus and a shared data bus. No read/write strobe reaches the connector. The block can therefore not see a write directly. It infers a write from the instruction stream it serves itself.

The display kernel is a run of store-zero-page instructions that write a register preloaded with all ones. Each time the block returns the store opcode byte (0x84) on an opcode fetch, it expects two more cycles. The first is the operand fetch, still a ROM read. The second is the write, which has the select address bit low. On that write the block pulls selected data lines low so that the value landing in the target register is the next byte from an update queue. It never drives a line high, so it never fights the CPU's high output. The engine is switched on only for the visible kernel.

Each CPU cycle is presented as one system clock with a cycle strobe high. Outputs are combinational for that clock. The sequence state advances on the edge that closes a strobed clock.

Top module: `opstuff_top`

## Requirements
- R1: In a strobed cycle with cpu_addr[12]=1, rom_addr equals cpu_addr[11:0], bus_dout equals rom_data and bus_oe is all ones.
- R2: A ROM byte of 0x84 served while idle with stuff_en=1 starts a sequence. The next strobed ROM read is served as the operand, and the strobed cycle after it with cpu_addr[12]=0 is a stuffed write.
- R3: On a stuffed write with q_valid=1, bus_dout is all zeros, bus_oe is the bitwise inverse of q_data, and q_pop is high for that one cycle. A queue byte of 0xFF gives bus_oe=0x00 and still pops.
- R4: A 0x84 byte returned as the operand does not start a new sequence, so the write that follows it is still stuffed.
- R5: A strobed cycle with cpu_addr[12]=0 that is not the write slot of a sequence leaves bus_oe at zero and q_pop low.
- R6: Either of two conditions leaves the write unstuffed: stuff_en=0 at the opcode fetch, or stuff_en=0 in the write slot.
- R7: A stuffed write with q_valid=0 drives nothing and does not pop. It sets underrun, which stays high until reset.
- R8: While bus_cycle is low, bus_oe is zero, q_pop is low and the sequence state does not advance.
- R9: A cycle with cpu_addr[12]=0 in the operand slot aborts the sequence without driving. The block then returns to idle.
- R10: Synchronous active-low reset clears underrun and returns the sequence to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cycle | input | 1 | High for the one clock that represents a CPU cycle |
| cpu_addr | input | 13 | CPU address bus; bit 12 selects the cartridge |
| stuff_en | input | 1 | Enables opcode triggering and write override |
| rom_addr | output | 12 | Address to the ROM read port |
| rom_data | input | 8 | Byte returned by the ROM read port, same clock |
| q_data | input | 8 | Head byte of the register-update queue |
| q_valid | input | 1 | Queue holds at least one byte |
| q_pop | output | 1 | Consume the queue head |
| bus_dout | output | 8 | Data driven onto the bus where enabled |
| bus_oe | output | 8 | Per-bit drive enable |
| underrun | output | 1 | Sticky flag: a stuffed write found the queue empty |

## Verification
The bench builds the block with its default parameters: a 13-bit address with bit 12 as the cartridge select, 8-bit data, and 0x84 as the trigger byte. These values make the real kernel byte patterns usable as stimulus. The bench presents a 0x84 operand, an all-ones queue byte that must pop without driving, enable dropping inside a sequence, strobe gaps between the cycles of one instruction, and an empty queue. The bench drives rom_data directly as the ROM model. This lets it place the trigger byte in any slot.

// File: rtl/opstuff_pkg.sv
// Shared types for the write-data override engine.
package opstuff_pkg;
    // Position inside one store-zero-page instruction.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPND  = 2'd1,
        ST_WRITE = 2'd2
    } stuff_state_e;
endpackage

// File: rtl/opstuff_fsm.sv
// Sequence tracker. Steps once per strobed CPU cycle, following
// opcode fetch -> operand fetch -> write slot.
// Assumes the fetched byte is the byte served to the CPU in the same clock.
module opstuff_fsm
    import opstuff_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] TRIG_OP = 8'h84
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              rom_cycle,
    input  logic [DATA_W-1:0] fetched,
    input  logic              stuff_en,
    output stuff_state_e      state,
    output logic              write_slot
);
    stuff_state_e nxt;
    logic         trig_hit;

    // An opcode fetch that carries the trigger byte while enabled.
    assign trig_hit   = rom_cycle && stuff_en && (fetched == TRIG_OP);
    // The write slot is only honoured on a low-select cycle while still enabled.
    assign write_slot = (state == ST_WRITE) && !rom_cycle && stuff_en;

    // Next-state choice for one CPU cycle.
    always_comb begin
        nxt = ST_IDLE;
        unique case (state)
            ST_IDLE:  nxt = trig_hit ? ST_OPND : ST_IDLE;
            ST_OPND:  nxt = rom_cycle ? ST_WRITE : ST_IDLE;
            ST_WRITE: nxt = trig_hit ? ST_OPND : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register, advanced only on strobed cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= ST_IDLE;
        else if (step) state <= nxt;
    end
endmodule

// File: rtl/opstuff_writer.sv
// Write override unit. In a write slot it pops the queue and enables
// only the bits that must be pulled low. Assumes the CPU writes all ones.
module opstuff_writer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot,
    input  logic              q_valid,
    input  logic [DATA_W-1:0] q_data,
    output logic              q_pop,
    output logic [DATA_W-1:0] stuff_oe,
    output logic              underrun
);
    // Pop and per-bit pull-down enables for the current slot.
    always_comb begin
        q_pop    = slot && q_valid;
        stuff_oe = q_pop ? ~q_data : '0;
    end

    // Sticky flag for a slot that found the queue empty.
    always_ff @(posedge clk) begin
        if (!rst_n)                underrun <= 1'b0;
        else if (slot && !q_valid) underrun <= 1'b1;
    end
endmodule

// File: rtl/opstuff_busmux.sv
// Data bus driver. Serves ROM bytes on select-high cycles and applies
// override enables otherwise. Drives nothing outside strobed cycles.
module opstuff_busmux #(
    parameter int DATA_W = 8
) (
    input  logic              step,
    input  logic              rom_cycle,
    input  logic [DATA_W-1:0] rom_data,
    input  logic [DATA_W-1:0] stuff_oe,
    output logic [DATA_W-1:0] bus_dout,
    output logic [DATA_W-1:0] bus_oe
);
    // Pick between a ROM read and a low-only override.
    always_comb begin
        if (step && rom_cycle) begin
            bus_dout = rom_data;
            bus_oe   = '1;
        end else begin
            bus_dout = '0;
            bus_oe   = step ? stuff_oe : '0;
        end
    end
endmodule

// File: rtl/opstuff_top.sv
// Top of the write-data override engine. It serves ROM reads and infers
// the write cycle of each triggering store from the opcode stream. On that
// write it overrides the data with queued bytes by pulling bits low.
// Assumes a one-clock bus_cycle strobe per CPU cycle and a same-clock ROM port.
module opstuff_top
    import opstuff_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] TRIG_OP = 8'h84
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_cycle,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                stuff_en,
    output logic [ADDR_W-2:0]   rom_addr,
    input  logic [DATA_W-1:0]   rom_data,
    input  logic [DATA_W-1:0]   q_data,
    input  logic                q_valid,
    output logic                q_pop,
    output logic [DATA_W-1:0]   bus_dout,
    output logic [DATA_W-1:0]   bus_oe,
    output logic                underrun
);
    localparam int SEL_BIT = ADDR_W - 1;

    stuff_state_e      state;
    logic              rom_cycle;
    logic              write_slot;
    logic [DATA_W-1:0] stuff_oe;

    // Address split into the cartridge select and the ROM offset.
    assign rom_cycle = cpu_addr[SEL_BIT];
    assign rom_addr  = cpu_addr[SEL_BIT-1:0];

    opstuff_fsm #(.DATA_W(DATA_W), .TRIG_OP(TRIG_OP)) fsm_i (
        .clk(clk), .rst_n(rst_n), .step(bus_cycle), .rom_cycle(rom_cycle),
        .fetched(rom_data), .stuff_en(stuff_en), .state(state),
        .write_slot(write_slot)
    );

    opstuff_writer #(.DATA_W(DATA_W)) wr_i (
        .clk(clk), .rst_n(rst_n), .slot(write_slot && bus_cycle),
        .q_valid(q_valid), .q_data(q_data), .q_pop(q_pop),
        .stuff_oe(stuff_oe), .underrun(underrun)
    );

    opstuff_busmux #(.DATA_W(DATA_W)) mux_i (
        .step(bus_cycle), .rom_cycle(rom_cycle), .rom_data(rom_data),
        .stuff_oe(stuff_oe), .bus_dout(bus_dout), .bus_oe(bus_oe)
    );
endmodule

// File: rtl/opstuff_chk.sv
// Property checker for opstuff_top, attached by bind.
module opstuff_chk #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cycle,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              stuff_en,
    input logic [DATA_W-1:0] rom_data,
    input logic              q_valid,
    input logic              q_pop,
    input logic [DATA_W-1:0] bus_dout,
    input logic [DATA_W-1:0] bus_oe,
    input logic              underrun
);
    // R1
    rom_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cycle && cpu_addr[ADDR_W-1]) |-> (bus_oe == '1 && bus_dout == rom_data));
    // R3
    low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cycle && !cpu_addr[ADDR_W-1]) |-> ((bus_dout & bus_oe) == '0));
    // R3
    pop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |-> (q_valid && bus_cycle && stuff_en && !cpu_addr[ADDR_W-1]));
    // R7
    underrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
    // R7
    underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(bus_cycle && !q_valid && !cpu_addr[ADDR_W-1]));
    // R8
    quiet_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cycle |-> (bus_oe == '0 && !q_pop));
endmodule

bind opstuff_top opstuff_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_cycle(bus_cycle), .cpu_addr(cpu_addr),
    .stuff_en(stuff_en), .rom_data(rom_data), .q_valid(q_valid),
    .q_pop(q_pop), .bus_dout(bus_dout), .bus_oe(bus_oe), .underrun(underrun)
);

// File: tb/opstuff_top_tb_top.sv
module opstuff_top_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cycle = 1'b0;
    logic [12:0] cpu_addr = '0;
    logic        stuff_en = 1'b0;
    logic [11:0] rom_addr;
    logic [7:0]  rom_data = '0;
    logic [7:0]  q_data = '0;
    logic        q_valid = 1'b0;
    logic        q_pop;
    logic [7:0]  bus_dout;
    logic [7:0]  bus_oe;
    logic        underrun;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    opstuff_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cycle(bus_cycle), .cpu_addr(cpu_addr),
        .stuff_en(stuff_en), .rom_addr(rom_addr), .rom_data(rom_data),
        .q_data(q_data), .q_valid(q_valid), .q_pop(q_pop),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .underrun(underrun)
    );

    typedef struct packed {
        logic       hi;
        logic [7:0] rd;
        logic       qv;
        logic [7:0] qd;
        logic       en;
        logic [7:0] e_oe;
        logic [7:0] e_do;
        logic       e_pop;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'hA9, 1'b0, 8'h00, 1'b1, 8'hFF, 8'hA9, 1'b0, 4'd1}, // R1 plain read
        '{1'b1, 8'h84, 1'b0, 8'h00, 1'b1, 8'hFF, 8'h84, 1'b0, 4'd2}, // R2 trigger
        '{1'b1, 8'h1B, 1'b0, 8'h00, 1'b1, 8'hFF, 8'h1B, 1'b0, 4'd2}, // R2 operand
        '{1'b0, 8'h00, 1'b1, 8'h11, 1'b1, 8'hEE, 8'h00, 1'b1, 4'd3}, // R3 stuffed
        '{1'b1, 8'h84, 1'b0, 8'h00, 1'b1, 8'hFF, 8'h84, 1'b0, 4'd2}, // R2 trigger
        '{1'b1, 8'h84, 1'b0, 8'h00, 1'b1, 8'hFF, 8'h84, 1'b0, 4'd4}, // R4 0x84 operand
        '{1'b0, 8'h00, 1'b1, 8'h22, 1'b1, 8'hDD, 8'h00, 1'b1, 4'd4}, // R4 still stuffed
        '{1'b1, 8'h85, 1'b0, 8'h00, 1'b1, 8'hFF, 8'h85, 1'b0, 4'd1}, // R1 other opcode
        '{1'b0, 8'h00, 1'b1, 8'h33, 1'b1, 8'h00, 8'h00, 1'b0, 4'd5}, // R5 stray write
        '{1'b1, 8'h84, 1'b0, 8'h00, 1'b0, 8'hFF, 8'h84, 1'b0, 4'd6}, // R6 disabled fetch
        '{1'b1, 8'h1B, 1'b0, 8'h00, 1'b0, 8'hFF, 8'h1B, 1'b0, 4'd6}, // R6
        '{1'b0, 8'h00, 1'b1, 8'h44, 1'b0, 8'h00, 8'h00, 1'b0, 4'd6}  // R6 no stuffing
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one clock at the falling edge; outputs are sampled 2 time units later.
    task automatic cyc(input logic bc, input logic hi, input logic [7:0] rd,
                       input logic qv, input logic [7:0] qd, input logic en);
        @(negedge clk);
        bus_cycle = bc;
        cpu_addr  = hi ? 13'h1234 : 13'h001B;
        rom_data  = rd;
        q_valid   = qv;
        q_data    = qd;
        stuff_en  = en;
        #2;
    endtask

    task automatic expect_out(input string req, input logic [7:0] eoe,
                              input logic [7:0] edo, input logic epop);
        chk(req, bus_oe, eoe);
        chk(req, bus_dout, edo);
        chk(req, q_pop, epop);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
        chk("R10", underrun, 0);
        chk("R8", bus_oe, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cyc(1'b1, VECS[i].hi, VECS[i].rd, VECS[i].qv, VECS[i].qd, VECS[i].en);
            if (bus_oe !== VECS[i].e_oe || bus_dout !== VECS[i].e_do || q_pop !== VECS[i].e_pop) begin
                $display("FAIL R%0d vec %0d actual oe=%h do=%h pop=%b expected oe=%h do=%h pop=%b",
                         VECS[i].req, i, bus_oe, bus_dout, q_pop,
                         VECS[i].e_oe, VECS[i].e_do, VECS[i].e_pop);
                bad++;
            end
            total++;
        end

        // R1 ROM address passthrough
        cyc(1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 1'b1);
        chk("R1", rom_addr, 12'h234);

        // R8 gaps inside a sequence hold state; R3 all-ones byte pops but drives nothing
        cyc(1'b1, 1'b1, 8'h84, 1'b0, 8'h00, 1'b1);
        cyc(1'b0, 1'b0, 8'h00, 1'b1, 8'h55, 1'b1);
        expect_out("R8", 8'h00, 8'h00, 1'b0);
        cyc(1'b1, 1'b1, 8'h1B, 1'b0, 8'h00, 1'b1);
        cyc(1'b0, 1'b0, 8'h00, 1'b1, 8'h66, 1'b1);
        expect_out("R8", 8'h00, 8'h00, 1'b0);
        cyc(1'b1, 1'b0, 8'h00, 1'b1, 8'hFF, 1'b1);
        expect_out("R3", 8'h00, 8'h00, 1'b1);

        // R9 abort in operand slot, then back to idle
        cyc(1'b1, 1'b1, 8'h84, 1'b0, 8'h00, 1'b1);
        cyc(1'b1, 1'b0, 8'h00, 1'b1, 8'h12, 1'b1);
        expect_out("R9", 8'h00, 8'h00, 1'b0);
        cyc(1'b1, 1'b0, 8'h00, 1'b1, 8'h12, 1'b1);
        expect_out("R9", 8'h00, 8'h00, 1'b0);

        // R6 enable dropped in the write slot
        cyc(1'b1, 1'b1, 8'h84, 1'b0, 8'h00, 1'b1);
        cyc(1'b1, 1'b1, 8'h06, 1'b0, 8'h00, 1'b1);
        cyc(1'b1, 1'b0, 8'h00, 1'b1, 8'h0F, 1'b0);
        expect_out("R6", 8'h00, 8'h00, 1'b0);

        // R7 empty queue at a stuffed write
        chk("R7", underrun, 0);
        cyc(1'b1, 1'b1, 8'h84, 1'b0, 8'h00, 1'b1);
        cyc(1'b1, 1'b1, 8'h06, 1'b0, 8'h00, 1'b1);
        cyc(1'b1, 1'b0, 8'h00, 1'b0, 8'h0F, 1'b1);
        expect_out("R7", 8'h00, 8'h00, 1'b0);
        cyc(1'b1, 1'b1, 8'hA9, 1'b0, 8'h00, 1'b1);
        chk("R7", underrun, 1);
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
        chk("R7", underrun, 1);

        // R10 reset clears the flag and the sequence
        cyc(1'b1, 1'b1, 8'h84, 1'b0, 8'h00, 1'b1);
        rst_n = 1'b0;
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
        rst_n = 1'b1;
        chk("R10", underrun, 0);
        cyc(1'b1, 1'b1, 8'h1B, 1'b0, 8'h00, 1'b1);
        cyc(1'b1, 1'b0, 8'h00, 1'b1, 8'h3C, 1'b1);
        expect_out("R10", 8'h00, 8'h00, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule